// File: doc/BRIEF.md
# Battery-Backed SRAM Supply Guard

This controller sits between a host driving an asynchronous SRAM-style bus and two 512K x 8 memory banks that are kept alive by a backup cell. Every clock it takes a digitized reading of the main supply in millivolts. From that reading it tracks one of three supply states: normal operation, write-protect, or running from the backup cell. A switch-select output tells the external power switch which source feeds the memory.

While the supply is healthy, the block turns the active-low host strobes into bank strobes. The top address bit picks one bank's chip select, and the low 19 address bits go to both banks. The read and write enables are gated so that a read and a write never drive the bus at the same time. While the supply is low, every host input is ignored, no bank strobe asserts and both data directions are released to high impedance.

After each write the block enforces a recovery gap. A host write strobe that starts too soon is refused for its whole length and sets a sticky error flag.

Top module: `bbsram_pwr_guard`

## Requirements
- R1: While reset is held, the supply state reads PROTECT (code 1). Both bank chip selects, the bank write enable and the bank output enable are high, both data drive enables are low, the backup select is low and the error flag is low.
- R2: In state NORMAL (code 0), the host read drive enable is high and the bank output enable is low exactly when chip enable is low, write enable is high and output enable is low. Read data passes from the banks to the host unchanged.
- R3: In state NORMAL with no recovery gap pending, the bank write enable and the bank data drive enable are active while both host chip enable and write enable are low. They go inactive in the same cycle that either strobe returns high.
- R4: If write enable falls while a read is driving the host bus, the host read drive enable and the bank output enable drop in that same cycle.
- R5: When the supply code drops below PFD_MV (default 4370) in NORMAL, the state becomes PROTECT (or BACKUP) at the next clock edge. From then on, all bank strobes stay inactive and both drive enables stay low, whatever the host strobes and address do.
- R6: A write in progress when protection takes effect has its bank write enable released on that same clock.
- R7: When the supply code is below SW_MV (default 3000), the next state is BACKUP (code 2) and the backup select is high. From BACKUP, a code above SW_MV returns the state to PROTECT and drops the backup select.
- R8: Leaving PROTECT for NORMAL needs a code strictly above RESUME_MV (default 4500). A code between PFD_MV and RESUME_MV keeps the block protected.
- R9: Address bit 19 selects the bank: 0 drives bank chip select bit 0 low, 1 drives bit 1 low, and the other bit stays high. Address bits 18..0 appear unchanged on the bank address.
- R10: For REC_CYC clocks (default 4) after a write ends, a write strobe that falls is refused for its whole assertion, and the error flag sets.
- R11: The error flag stays set until reset. Nothing in PROTECT or BACKUP sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_mv | input | 16 | Supply reading in millivolts, unsigned |
| host_addr | input | 20 | Host byte address |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_dq_in | input | 8 | Write data from the host |
| host_dq_out | output | 8 | Read data toward the host |
| host_dq_oe | output | 1 | Drive enable for host_dq_out |
| bank_addr | output | 19 | Address shared by both banks |
| bank_ce_n | output | 2 | Per-bank chip selects, active low |
| bank_we_n | output | 1 | Bank write enable, active low |
| bank_oe_n | output | 1 | Bank output enable, active low |
| bank_dq_wr | output | 8 | Write data toward the banks |
| bank_dq_oe | output | 1 | Drive enable for bank_dq_wr |
| bank_dq_rd | input | 8 | Read data from the banks |
| use_backup | output | 1 | High selects the backup cell as memory supply |
| sup_state | output | 2 | Supply state: 0 NORMAL, 1 PROTECT, 2 BACKUP |
| rec_err | output | 1 | Sticky flag for a write strobe refused during recovery |

## Verification
Reads are tried at both values of address bit 19 and with output enable high, which shows whether bank decoding is separate from read-driver gating. A read followed by a falling write strobe shows whether the read drivers are released as soon as the write takes over. Writes are ended once by write enable and once by chip enable, and a too-early second write strobe checks whether recovery blocks the write and sets the error flag. The supply code is then walked down through the protect and switchover levels and back up past each of them, once while a write is in progress. This shows whether the write is cut, the hysteresis, and whether toggled host inputs reach the banks while protected.

// File: rtl/bbsram_pkg.sv
`timescale 1ns/1ps
package bbsram_pkg;

  typedef enum logic [1:0] {
    SUP_NORMAL  = 2'd0,
    SUP_PROTECT = 2'd1,
    SUP_BACKUP  = 2'd2
  } sup_e;

  // Next supply state from the present state and the supply reading.
  function automatic sup_e f_sup_next(input sup_e cur, input int unsigned mv,
                                      input int unsigned pfd, input int unsigned sw,
                                      input int unsigned res);
    sup_e nxt;
    nxt = cur;
    case (cur)
      SUP_NORMAL: begin
        if (mv < sw)       nxt = SUP_BACKUP;
        else if (mv < pfd) nxt = SUP_PROTECT;
      end
      SUP_PROTECT: begin
        if (mv < sw)       nxt = SUP_BACKUP;
        else if (mv > res) nxt = SUP_NORMAL;
      end
      default: begin
        if (mv > sw)       nxt = SUP_PROTECT;
        else               nxt = SUP_BACKUP;
      end
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/bbsram_supply_fsm.sv
`timescale 1ns/1ps
module bbsram_supply_fsm
  import bbsram_pkg::*;
#(
  parameter int MV_W      = 16,
  parameter int PFD_MV    = 4370,
  parameter int SW_MV     = 3000,
  parameter int RESUME_MV = 4500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] supply_mv,
  output sup_e            st_q,
  output logic            normal,
  output logic            on_backup
);
  localparam logic [MV_W-1:0] PFD_L = MV_W'(PFD_MV);
  localparam logic [MV_W-1:0] SW_L  = MV_W'(SW_MV);
  localparam logic [MV_W-1:0] RES_L = MV_W'(RESUME_MV);

  sup_e st_d;

  always_comb st_d = f_sup_next(st_q, 32'(supply_mv), 32'(PFD_MV), 32'(SW_MV), 32'(RESUME_MV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SUP_PROTECT;
    else        st_q <= st_d;
  end

  assign normal    = (st_q == SUP_NORMAL);
  assign on_backup = (st_q == SUP_BACKUP);

  p_drop_protects_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SUP_NORMAL && supply_mv < PFD_L) |=> (st_q != SUP_NORMAL));

  p_no_early_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SUP_NORMAL && supply_mv <= RES_L) |=> (st_q != SUP_NORMAL));

  p_switch_to_cell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_mv < SW_L) |=> on_backup);

  p_leave_cell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (on_backup && supply_mv > SW_L) |=> (st_q == SUP_PROTECT));

endmodule

// File: rtl/bbsram_access_gate.sv
`timescale 1ns/1ps
module bbsram_access_gate #(
  parameter int REC_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic normal,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic sel_go,
  output logic wr_go,
  output logic rd_go,
  output logic rec_busy,
  output logic err_q
);
  localparam int CNT_W = $clog2(REC_CYC + 1);

  logic             ce_act, we_act, oe_act;
  logic             we_prev_q, wr_q, lock_q;
  logic [CNT_W-1:0] rec_q;
  logic             we_fall, wr_end, blocked;

  assign ce_act   = !ce_n;
  assign we_act   = !we_n;
  assign oe_act   = !oe_n;
  assign we_fall  = we_act && !we_prev_q;
  assign rec_busy = (rec_q != '0);
  assign blocked  = lock_q || rec_busy;

  assign sel_go = normal && ce_act;
  assign wr_go  = sel_go && we_act && !blocked;
  assign rd_go  = sel_go && !we_act && oe_act;
  assign wr_end = wr_q && !wr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q <= 1'b0;
      wr_q      <= 1'b0;
      lock_q    <= 1'b0;
      rec_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      we_prev_q <= we_act;
      wr_q      <= wr_go;
      lock_q    <= we_act && (lock_q || (normal && rec_busy));
      if (wr_end)        rec_q <= CNT_W'(REC_CYC);
      else if (rec_busy) rec_q <= rec_q - 1'b1;
      if (normal && we_fall && rec_busy) err_q <= 1'b1;
    end
  end

  p_protect_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !normal |-> (!wr_go && !rd_go && !sel_go));

  p_cut_on_protect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !normal) |-> 1'b0 or (!normal |-> !wr_go));

  p_late_we_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_fall && rec_busy) |-> !wr_go);

  p_gap_follows_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> rec_busy);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/bbsram_bank_decode.sv
`timescale 1ns/1ps
module bbsram_bank_decode #(
  parameter int ADDR_W = 20,
  parameter int SEL_W  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_go,
  output logic [(1<<SEL_W)-1:0]   bank_ce_n,
  output logic [ADDR_W-SEL_W-1:0] bank_addr
);
  localparam int NB = 1 << SEL_W;

  logic [SEL_W-1:0] bank_idx;
  assign bank_idx  = addr[ADDR_W-1 -: SEL_W];
  assign bank_addr = addr[ADDR_W-SEL_W-1:0];

  for (genvar b = 0; b < NB; b++) begin : g_cs
    assign bank_ce_n[b] = !(sel_go && bank_idx == SEL_W'(b));
  end

  p_one_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_go |-> ($countones(~bank_ce_n) == 1));

  p_idle_banks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_go |-> (&bank_ce_n));

endmodule

// File: rtl/bbsram_pwr_guard.sv
`timescale 1ns/1ps
module bbsram_pwr_guard
  import bbsram_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int MV_W      = 16,
  parameter int PFD_MV    = 4370,
  parameter int SW_MV     = 3000,
  parameter int RESUME_MV = 4500,
  parameter int REC_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MV_W-1:0]   supply_mv,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_ce_n,
  input  logic              host_we_n,
  input  logic              host_oe_n,
  input  logic [DATA_W-1:0] host_dq_in,
  output logic [DATA_W-1:0] host_dq_out,
  output logic              host_dq_oe,
  output logic [ADDR_W-2:0] bank_addr,
  output logic [1:0]        bank_ce_n,
  output logic              bank_we_n,
  output logic              bank_oe_n,
  output logic [DATA_W-1:0] bank_dq_wr,
  output logic              bank_dq_oe,
  input  logic [DATA_W-1:0] bank_dq_rd,
  output logic              use_backup,
  output logic [1:0]        sup_state,
  output logic              rec_err
);
  sup_e st_q;
  logic normal, on_backup, sel_go, wr_go, rd_go, rec_busy;

  bbsram_supply_fsm #(
    .MV_W(MV_W), .PFD_MV(PFD_MV), .SW_MV(SW_MV), .RESUME_MV(RESUME_MV)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_mv(supply_mv),
    .st_q(st_q), .normal(normal), .on_backup(on_backup)
  );

  bbsram_access_gate #(.REC_CYC(REC_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .normal(normal),
    .ce_n(host_ce_n), .we_n(host_we_n), .oe_n(host_oe_n),
    .sel_go(sel_go), .wr_go(wr_go), .rd_go(rd_go),
    .rec_busy(rec_busy), .err_q(rec_err)
  );

  bbsram_bank_decode #(.ADDR_W(ADDR_W), .SEL_W(1)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(host_addr), .sel_go(sel_go),
    .bank_ce_n(bank_ce_n), .bank_addr(bank_addr)
  );

  assign bank_we_n   = !wr_go;
  assign bank_dq_oe  = wr_go;
  assign bank_dq_wr  = host_dq_in;
  assign bank_oe_n   = !rd_go;
  assign host_dq_oe  = rd_go;
  assign host_dq_out = bank_dq_rd;
  assign use_backup  = on_backup;
  assign sup_state   = st_q;

  p_read_released_by_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we_n) |-> (bank_oe_n && !host_dq_oe));

  p_write_needs_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ce_n || host_we_n) |-> (bank_we_n && !bank_dq_oe));

  p_gap_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_we_n && rec_busy) |-> 1'b0 or (rec_busy |-> bank_we_n));

endmodule

// File: tb/test_bbsram_pwr_guard.sv
`timescale 1ns/1ps
module test_bbsram_pwr_guard;
  localparam int REC = 4;
  localparam int PFD = 4370, SWV = 3000, RES = 4500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] supply_mv = 16'd5000;
  logic [19:0] host_addr = '0;
  logic        host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
  logic [7:0]  host_dq_in = '0, bank_dq_rd = 8'h5A;
  logic [7:0]  host_dq_out, bank_dq_wr;
  logic        host_dq_oe, bank_we_n, bank_oe_n, bank_dq_oe, use_backup, rec_err;
  logic [18:0] bank_addr;
  logic [1:0]  bank_ce_n, sup_state;

  int vec = 0, bad = 0;

  always #10 clk = ~clk;

  bbsram_pwr_guard i_bbsram_pwr_guard (
    .clk(clk), .rst_n(rst_n), .supply_mv(supply_mv), .host_addr(host_addr),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
    .host_dq_in(host_dq_in), .host_dq_out(host_dq_out), .host_dq_oe(host_dq_oe),
    .bank_addr(bank_addr), .bank_ce_n(bank_ce_n), .bank_we_n(bank_we_n),
    .bank_oe_n(bank_oe_n), .bank_dq_wr(bank_dq_wr), .bank_dq_oe(bank_dq_oe),
    .bank_dq_rd(bank_dq_rd), .use_backup(use_backup), .sup_state(sup_state),
    .rec_err(rec_err)
  );

  // Behavioural reference: supply state 0/1/2, recovery count, lock, error.
  int m_st = 1, m_rec = 0;
  bit m_lock = 0, m_weprev = 0, m_wrq = 0, m_err = 0;

  function automatic bit f_wr();
    return (m_st == 0) && !host_ce_n && !host_we_n && !m_lock && (m_rec == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 1; m_rec = 0; m_lock = 0; m_weprev = 0; m_wrq = 0; m_err = 0;
    end else begin
      bit wr, wea, nrm;
      int mv;
      wr  = f_wr();
      wea = !host_we_n;
      nrm = (m_st == 0);
      mv  = supply_mv;
      if (nrm && wea && !m_weprev && m_rec > 0) m_err = 1;
      m_lock = wea && (m_lock || (nrm && m_rec > 0));
      if (m_wrq && !wr) m_rec = REC;
      else if (m_rec > 0) m_rec = m_rec - 1;
      m_wrq = wr;
      m_weprev = wea;
      if (m_st == 0)      m_st = (mv < SWV) ? 2 : (mv < PFD) ? 1 : 0;
      else if (m_st == 1) m_st = (mv < SWV) ? 2 : (mv > RES) ? 0 : 1;
      else                m_st = (mv > SWV) ? 1 : 2;
    end
  end

  task automatic check(input string tag);
    bit nrm, wr, rd;
    logic [1:0] ce_e;
    logic [9:0] got_c, exp_c;
    logic [34:0] got_d, exp_d;
    nrm  = (m_st == 0);
    wr   = f_wr();
    rd   = nrm && !host_ce_n && host_we_n && !host_oe_n;
    ce_e = (nrm && !host_ce_n) ? (host_addr[19] ? 2'b01 : 2'b10) : 2'b11;
    exp_c = {ce_e, !wr, !rd, rd, wr, (m_st == 2), 2'(m_st), m_err};
    got_c = {bank_ce_n, bank_we_n, bank_oe_n, host_dq_oe, bank_dq_oe, use_backup,
             sup_state, rec_err};
    vec++;
    if (got_c !== exp_c) begin
      bad++;
      $display("FAIL %s control: actual %b expected %b", tag, got_c, exp_c);
    end
    exp_d = {host_addr[18:0], bank_dq_rd, host_dq_in};
    got_d = {bank_addr, host_dq_out, bank_dq_wr};
    vec++;
    if (got_d !== exp_d) begin
      bad++;
      $display("FAIL %s data: actual %h expected %h", tag, got_d, exp_d);
    end
  endtask

  task automatic apply(input bit ce, input bit we, input bit oe, input logic [19:0] a,
                       input logic [7:0] d, input int mv, input string tag);
    @(negedge clk);
    host_ce_n = ce; host_we_n = we; host_oe_n = oe;
    host_addr = a; host_dq_in = d; supply_mv = 16'(mv);
    #2 check(tag);
  endtask

  task automatic idle(input int n, input int mv, input string tag);
    for (int i = 0; i < n; i++) apply(1, 1, 1, 20'h0, 8'h00, mv, tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    idle(2, 5000, "R1");
    rst_n = 1'b1;
    // R8: leaves PROTECT after one edge with a high reading
    idle(2, 5000, "R8");
    // R2 / R9: reads in both banks, and with output enable high
    apply(0, 1, 0, 20'h00123, 8'h00, 5000, "R2");
    bank_dq_rd = 8'hC3;
    apply(0, 1, 0, 20'h80456, 8'h00, 5000, "R9");
    apply(0, 1, 1, 20'h80456, 8'h00, 5000, "R2");
    // R4: write enable falls during a read
    apply(0, 1, 0, 20'h00777, 8'h11, 5000, "R4");
    apply(0, 0, 0, 20'h00777, 8'h22, 5000, "R4");
    // R3: write ended by write enable
    apply(0, 0, 1, 20'h80010, 8'h33, 5000, "R3");
    apply(0, 1, 1, 20'h80010, 8'h33, 5000, "R3");
    // R10: early write strobe refused, error sets
    apply(1, 1, 1, 20'h80010, 8'h00, 5000, "R10");
    apply(0, 0, 1, 20'h80011, 8'h44, 5000, "R10");
    for (int i = 0; i < 6; i++) apply(0, 0, 1, 20'h80011, 8'h44, 5000, "R10");
    // R11: error holds
    idle(6, 5000, "R11");
    // R3: fresh write accepted, ended by chip enable
    apply(0, 0, 1, 20'h00020, 8'h55, 5000, "R3");
    apply(1, 0, 1, 20'h00020, 8'h55, 5000, "R3");
    idle(6, 5000, "R3");
    // R6: write cut when the supply drops
    apply(0, 0, 1, 20'h00030, 8'h66, 5000, "R6");
    apply(0, 0, 1, 20'h00030, 8'h66, 4000, "R6");
    apply(0, 0, 1, 20'h00030, 8'h66, 4000, "R6");
    // R5: host inputs ignored while protected
    apply(0, 1, 0, 20'h80040, 8'h77, 4000, "R5");
    apply(1, 0, 0, 20'hFFFFF, 8'h88, 4000, "R5");
    apply(0, 0, 1, 20'h00001, 8'h99, 4000, "R5");
    // R8: between the thresholds stays protected
    apply(0, 1, 0, 20'h00001, 8'h00, 4400, "R8");
    idle(3, 4500, "R8");
    // R7: switchover to the cell and back
    idle(3, 2900, "R7");
    apply(0, 0, 0, 20'h80001, 8'hAA, 2900, "R7");
    idle(3, 3100, "R7");
    idle(2, 4400, "R8");
    idle(3, 4600, "R8");
    apply(0, 1, 0, 20'h80abc, 8'h00, 4600, "R2");
    // R7: straight drop from NORMAL below the switchover level
    idle(3, 2500, "R7");
    idle(2, 5000, "R7");
    idle(2, 5000, "R11");
    finish_run();
  end
endmodule